// File: doc/BRIEF.md
# Debug-Aware Reset Mode Controller

This block turns three board pins into the chip-level reset controls. The pins are a mode select, a power-on reset and a test-port reset. The block drives three outputs: an active-low CPU reset, an active-low debug-interface reset and a CPU start enable. It also drives a status flag that shows when a reset hold is latched. Every pin passes through a two-flop synchroniser. Each reset pin clears its synchroniser asynchronously, so a reset takes effect at once. Release is synchronous, two clocks after the pin rises.

In normal mode the two reset pins map straight onto the two reset outputs. Emulation mode adds a latched hold. A hold is entered when both reset pins stay low for a qualifying run of clock cycles. While the hold is latched, the CPU stays in reset even after the power-on pin goes high. The test-port reset can still be released, so an attached debugger can talk to the chip before the CPU runs. Only a fresh assertion of either reset pin clears the hold.

The block has no data path and no handshake. All of its pins are plain level control and status signals.

Top module: `dbg_rst_ctrl`

## Requirements
- R1: `mode_pin` is synchronised through two flops; 1 selects normal mode, 0 selects emulation mode.
- R2: With both reset pins low, `cpu_rst_n` and `dbg_rst_n` are both 0.
- R3: With only `por_n` low, only `cpu_rst_n` is 0. With only `trst_n` low, only `dbg_rst_n` is 0. With both high and no hold, both outputs are 1.
- R4: A reset output goes to 0 in the same cycle as its pin falls. It returns to 1 after the second rising clock edge following the pin's rise.
- R5: `cpu_run` goes to 1 one rising edge after `cpu_rst_n` is released, and drops to 0 together with `cpu_rst_n`.
- R6: In emulation mode, `hold_active` becomes 1 on the HOLD_CYC-th consecutive rising edge at which both synchronised reset pins are low. Any break in that run restarts the count from zero.
- R7: While `hold_active` is 1, `cpu_rst_n` and `cpu_run` stay 0 whatever `por_n` does, and `dbg_rst_n` still follows `trst_n`.
- R8: A new falling edge of the synchronised `por_n` clears the hold on the next rising edge.
- R9: A new falling edge of the synchronised `trst_n` clears the hold on the next rising edge. If `por_n` is high, `cpu_rst_n` is then released.
- R10: In normal mode no hold is entered, however long both pins stay low. A hold is cleared within three rising edges of `mode_pin` going high.
- R11: `hold_active` reports the latched hold state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| mode_pin | input | 1 | 1 = normal mode, 0 = emulation mode |
| por_n | input | 1 | Power-on reset pin, active low |
| trst_n | input | 1 | Test-port reset pin, active low |
| cpu_rst_n | output | 1 | CPU reset, active low |
| dbg_rst_n | output | 1 | Debug-interface reset, active low |
| cpu_run | output | 1 | CPU start enable |
| hold_active | output | 1 | 1 while a reset hold is latched |

## Verification
The bench sweeps all four reset-pin combinations in both modes.

It runs the hold count to exactly one cycle short of the limit and then to the limit itself. A counter that is off by one would latch the hold a cycle early or a cycle late. It breaks a run of low cycles partway through to catch a counter that keeps its value instead of restarting. It holds both pins low for a long time in normal mode, which would expose a hold entered regardless of mode.

It exercises each cancel path, and it releases the power-on pin during a hold. An edge detector wired to the wrong pin would leave the CPU stuck in reset. A design that ignored the hold would let the CPU start too early. It also times release and start enable to the exact edge, so a missing or extra synchroniser stage is caught.

// File: rtl/dbg_rst_pkg.sv
package dbg_rst_pkg;
  localparam int unsigned SYNC_DEPTH = 2;

  typedef struct packed {
    logic normal;   // synchronised mode select, 1 = normal
    logic por_ok;   // synchronised power-on pin, 0 = asserted
    logic trst_ok;  // synchronised test reset pin, 0 = asserted
  } pin_state_t;
endpackage

// File: rtl/drc_sync.sv
module drc_sync #(
  parameter int unsigned STAGES    = 2,
  parameter bit          ASYNC_CLR = 1'b1
) (
  input  logic clk,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] q;

  generate
    if (ASYNC_CLR) begin : g_clr
      // low input clears the chain at once, release ripples through
      always_ff @(posedge clk or negedge din) begin
        if (!din) q <= '0;
        else      q <= {q[STAGES-2:0], 1'b1};
      end
    end else begin : g_plain
      always_ff @(posedge clk) q <= {q[STAGES-2:0], din};
    end
  endgenerate

  assign dout = q[STAGES-1];
endmodule

// File: rtl/drc_hold.sv
module drc_hold
  import dbg_rst_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 16
) (
  input  logic       clk,
  input  pin_state_t pins,
  output logic       hold
);
  localparam int unsigned CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  logic [CW-1:0] cnt;
  logic          por_q, trst_q;
  logic          qualify, cancel;

  assign qualify = !pins.normal && !pins.por_ok && !pins.trst_ok;
  assign cancel  = (por_q && !pins.por_ok) || (trst_q && !pins.trst_ok);

  always_ff @(posedge clk) begin
    por_q  <= pins.por_ok;
    trst_q <= pins.trst_ok;
  end

  always_ff @(posedge clk) begin
    if (!qualify)        cnt <= '0;
    else if (cnt < LAST) cnt <= cnt + 1'b1;
    else                 cnt <= LAST;
  end

  always_ff @(posedge clk) begin
    if (pins.normal || cancel)     hold <= 1'b0;
    else if (qualify && cnt == LAST) hold <= 1'b1;
  end
endmodule

// File: rtl/drc_outs.sv
module drc_outs
  import dbg_rst_pkg::*;
(
  input  logic       clk,
  input  pin_state_t pins,
  input  logic       hold,
  output logic       cpu_rst_n,
  output logic       dbg_rst_n,
  output logic       cpu_run
);
  assign cpu_rst_n = pins.por_ok & ~hold;
  assign dbg_rst_n = pins.trst_ok;

  always_ff @(posedge clk or negedge cpu_rst_n) begin
    if (!cpu_rst_n) cpu_run <= 1'b0;
    else            cpu_run <= 1'b1;
  end
endmodule

// File: rtl/dbg_rst_ctrl.sv
module dbg_rst_ctrl
  import dbg_rst_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 16
) (
  input  logic clk,
  input  logic mode_pin,
  input  logic por_n,
  input  logic trst_n,
  output logic cpu_rst_n,
  output logic dbg_rst_n,
  output logic cpu_run,
  output logic hold_active
);
  logic       mode_sync, por_sync, trst_sync;
  pin_state_t pins;

  drc_sync #(.STAGES(SYNC_DEPTH), .ASYNC_CLR(1'b0)) u_mode (
    .clk(clk), .din(mode_pin), .dout(mode_sync));
  drc_sync #(.STAGES(SYNC_DEPTH), .ASYNC_CLR(1'b1)) u_por (
    .clk(clk), .din(por_n), .dout(por_sync));
  drc_sync #(.STAGES(SYNC_DEPTH), .ASYNC_CLR(1'b1)) u_trst (
    .clk(clk), .din(trst_n), .dout(trst_sync));

  assign pins = '{normal: mode_sync, por_ok: por_sync, trst_ok: trst_sync};

  drc_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk(clk), .pins(pins), .hold(hold_active));

  drc_outs u_outs (
    .clk(clk), .pins(pins), .hold(hold_active),
    .cpu_rst_n(cpu_rst_n), .dbg_rst_n(dbg_rst_n), .cpu_run(cpu_run));
endmodule

// File: rtl/drc_checker.sv
module drc_checker (
  input logic clk,
  input logic por_n,
  input logic trst_n,
  input logic mode_pin,
  input logic cpu_rst_n,
  input logic dbg_rst_n,
  input logic cpu_run,
  input logic hold_active,
  input logic mode_s,
  input logic por_s,
  input logic trst_s
);
  assert_por_asserts_cpu_R4: assert property (@(posedge clk) disable iff (por_n)
    1'b1 |-> !cpu_rst_n);

  assert_trst_asserts_dbg_R4: assert property (@(posedge clk) disable iff (por_n && trst_n)
    !trst_n |-> !dbg_rst_n);

  assert_hold_stops_cpu_R7: assert property (@(posedge clk) disable iff (!por_n)
    hold_active |-> (!cpu_rst_n && !cpu_run));

  assert_run_needs_release_R5: assert property (@(posedge clk) disable iff (!por_n)
    cpu_run |-> cpu_rst_n);

  assert_entry_needs_both_low_R6: assert property (@(posedge clk) disable iff (mode_pin)
    $rose(hold_active) |-> ($past(!por_s) && $past(!trst_s) && $past(!mode_s)));

  assert_por_cancel_R8: assert property (@(posedge clk) disable iff (mode_pin)
    ($fell(por_s) && $past(hold_active)) |=> !hold_active);

  assert_trst_cancel_R9: assert property (@(posedge clk) disable iff (mode_pin)
    ($fell(trst_s) && $past(hold_active)) |=> !hold_active);

  assert_normal_no_hold_R10: assert property (@(posedge clk) disable iff (!mode_pin)
    mode_s |=> !hold_active);
endmodule

bind dbg_rst_ctrl drc_checker u_chk (
  .clk(clk), .por_n(por_n), .trst_n(trst_n), .mode_pin(mode_pin),
  .cpu_rst_n(cpu_rst_n), .dbg_rst_n(dbg_rst_n), .cpu_run(cpu_run),
  .hold_active(hold_active), .mode_s(mode_sync), .por_s(por_sync),
  .trst_s(trst_sync));

// File: tb/dbg_rst_ctrl_bench.sv
`timescale 1ns/1ps
module dbg_rst_ctrl_bench;
  localparam int HOLD = 16;

  logic clk = 1'b0;
  logic mode_pin, por_n, trst_n;
  logic cpu_rst_n, dbg_rst_n, cpu_run, hold_active;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  dbg_rst_ctrl #(.HOLD_CYC(HOLD)) u_dbg_rst_ctrl (
    .clk(clk), .mode_pin(mode_pin), .por_n(por_n), .trst_n(trst_n),
    .cpu_rst_n(cpu_rst_n), .dbg_rst_n(dbg_rst_n), .cpu_run(cpu_run),
    .hold_active(hold_active));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", what, act, exp);
    end
  endtask

  task automatic outs(input logic c, input logic d, input logic r,
                      input logic h, input string tag);
    chk(cpu_rst_n,   c, {tag, " cpu_rst_n"});
    chk(dbg_rst_n,   d, {tag, " dbg_rst_n"});
    chk(cpu_run,     r, {tag, " cpu_run"});
    chk(hold_active, h, {tag, " hold_active"});
  endtask

  initial begin
    mode_pin = 1'b1; por_n = 1'b0; trst_n = 1'b0;
    tick(3);
    outs(0, 0, 0, 0, "R2 reset state");

    // R1 R2 R3: sweep pin combinations in both modes
    for (int m = 1; m >= 0; m--) begin
      mode_pin = m[0];
      for (int p = 0; p < 4; p++) begin
        por_n = 1'b1; trst_n = 1'b1;
        tick(4);
        por_n = p[1]; trst_n = p[0];
        tick(4);
        outs(p[1], p[0], p[1], 0, m ? "R3 normal decode" : "R1 emu decode");
      end
    end

    // R4 R5: async assertion, synchronous release, start enable
    mode_pin = 1'b1; por_n = 1'b1; trst_n = 1'b1;
    tick(4);
    por_n = 1'b0; #1;
    chk(cpu_rst_n, 0, "R4 async assert");
    chk(cpu_run,   0, "R5 run drops with reset");
    tick(1); por_n = 1'b1;
    tick(1); chk(cpu_rst_n, 0, "R4 release one edge");
    tick(1); chk(cpu_rst_n, 1, "R4 release two edges");
    chk(cpu_run, 0, "R5 run waits");
    tick(1); chk(cpu_run, 1, "R5 run one edge later");
    trst_n = 1'b0; #1; chk(dbg_rst_n, 0, "R4 dbg async assert");
    tick(1); trst_n = 1'b1; tick(2); chk(dbg_rst_n, 1, "R4 dbg release");

    // R10: normal mode never holds
    por_n = 1'b0; trst_n = 1'b0;
    tick(3 * HOLD);
    chk(hold_active, 0, "R10 no hold in normal");
    por_n = 1'b1; trst_n = 1'b1; tick(3);
    outs(1, 1, 1, 0, "R10 normal release");

    // R6: exact qualification length in emulation mode
    mode_pin = 1'b0; tick(3);
    por_n = 1'b0; trst_n = 1'b0;
    tick(HOLD - 1); chk(hold_active, 0, "R6 one short");
    tick(1);        chk(hold_active, 1, "R6 at limit");

    // R7: por release ignored, trst release honoured
    por_n = 1'b1; tick(4);
    outs(0, 0, 0, 1, "R7 por high in hold");
    trst_n = 1'b1; tick(3);
    outs(0, 1, 0, 1, "R7 dbg up in hold");

    // R9: cancel by new trst assertion
    trst_n = 1'b0; tick(1);
    chk(hold_active, 0, "R9 trst cancel");
    chk(cpu_rst_n,   1, "R9 cpu released");
    tick(1); chk(cpu_run, 1, "R9 run");
    trst_n = 1'b1; tick(3);

    // R8: re-enter, then cancel by new por assertion
    por_n = 1'b0; trst_n = 1'b0; tick(HOLD);
    chk(hold_active, 1, "R11 re-entered");
    por_n = 1'b1; trst_n = 1'b1; tick(4);
    outs(0, 1, 0, 1, "R7 held after both up");
    por_n = 1'b0; tick(1);
    chk(hold_active, 0, "R8 por cancel");
    chk(cpu_rst_n,   0, "R8 cpu still in reset");
    por_n = 1'b1; tick(2);
    chk(cpu_rst_n, 1, "R8 cpu released");
    tick(1); chk(cpu_run, 1, "R8 run");

    // R6: interrupted run restarts count
    por_n = 1'b0; trst_n = 1'b0; tick(HOLD - 6);
    trst_n = 1'b1; tick(3);
    chk(hold_active, 0, "R6 broken run");
    trst_n = 1'b0;
    tick(HOLD - 1); chk(hold_active, 0, "R6 restart one short");
    tick(1);        chk(hold_active, 1, "R6 restart at limit");

    // R10: switching to normal clears hold
    mode_pin = 1'b1; tick(3);
    chk(hold_active, 0, "R10 mode clears hold");
    por_n = 1'b1; trst_n = 1'b1; tick(3);
    outs(1, 1, 1, 0, "R10 normal after clear");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule